// File: doc/BRIEF.md
# Serial Channel Transmit/Receive FIFO Pair

This block gives one serial channel a transmit FIFO and a receive FIFO behind a small register bus. Software moves payload through a single data address. A write to that address queues a byte for transmission. A read from the same address takes the oldest received byte. The serial engine sits on the other side. It drains the transmit FIFO through a pop port and fills the receive FIFO through a push port.

For every FIFO the block derives four conditions from an exact fill counter: empty, full, almost-empty and almost-full. The two almost trip points are set by software. The conditions can be read in a status register, where they are encoded active-low. Each condition also feeds an edge-detecting interrupt source, which has a sticky pending bit and an enable bit. A separate bit for each FIFO discards that FIFO's contents at once.

Top module: `chan_fifo_pair`

## Requirements
- R1: A bus write to address 0 pushes `bus_wdata_i[7:0]` into the transmit FIFO. A bus read of address 0 returns the receive FIFO head, zero-extended, and pops it at that clock edge.
- R2: Both FIFOs keep first-in first-out order. Address 2 reads the transmit fill count and address 3 reads the receive fill count. Each count is exact and ranges from 0 to 256.
- R3: A bus write to a full transmit FIFO is discarded, and so is a serial push into a full receive FIFO. Neither changes the count or the contents. Fullness is judged before any pop in the same cycle.
- R4: A bus read of address 0 while the receive FIFO is empty returns 0 and changes no state.
- R5: Address 1 reads the condition flags inverted (0 = condition true). Bits [3:0] belong to the transmit FIFO and bits [7:4] to the receive FIFO. Within each nibble the order is bit0 empty, bit1 full, bit2 almost-empty, bit3 almost-full. After reset the register reads 0x00AA.
- R6: Almost-empty holds when count <= AE, and almost-full holds when count >= 256 - AF. The transmit thresholds are at address 4 and the receive thresholds at address 5, each as {AF[15:8], AE[7:0]}. Both thresholds reset to 16.
- R7: Writing address 1 with bit0 set empties the transmit FIFO, and writing it with bit1 set empties the receive FIFO. The count is 0 after that edge, and the clear overrides any push or pop in the same cycle.
- R8: Address 6 holds pending bits, laid out like the R5 flag bits but active-high. A pending bit sets on the clock edge after its condition becomes true. Writing 1 to a pending bit clears it, but a new set in the same cycle wins.
- R9: Address 7 holds the enable mask, which resets to 0. `irq_o` is high exactly when some pending bit and its enable bit are both set.
- R10: `tx_valid_o` is high when the transmit FIFO holds data, and `tx_data_o` shows its head. `tx_pop_i` removes the head when the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (pops on data address) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| tx_pop_i | input | 1 | Serial side takes transmit head |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_data_o | output | 8 | Transmit FIFO head |
| rx_push_i | input | 1 | Serial side stores a received byte |
| rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Enabled pending interrupt present |

## Verification
The bench fills each FIFO to 256 and then pushes twice more. A design that wrapped its pointers or used an 8-bit count would report 0 or overwrite the oldest byte at that point. It reads the data address on an empty receive FIFO, which would expose a read that returned stale memory or moved the pointer. It programs small thresholds and walks the count across both trip points, which catches an off-by-one in `<=`/`>=` or a reversed almost-full subtraction. It also checks pending bits in the cycle after each condition rises, so an interrupt that was level-sensitive, sampled one cycle early, or missed after a FIFO clear shows up as a mismatch.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_TXCNT = 3'd2;
  localparam logic [2:0] ADDR_RXCNT = 3'd3;
  localparam logic [2:0] ADDR_TXTHR = 3'd4;
  localparam logic [2:0] ADDR_RXTHR = 3'd5;
  localparam logic [2:0] ADDR_PEND  = 3'd6;
  localparam logic [2:0] ADDR_IEN   = 3'd7;

  typedef struct packed {
    logic af;
    logic ae;
    logic full;
    logic empty;
  } fifo_flags_t;

  // flags of an empty FIFO with threshold < depth
  localparam fifo_flags_t FLAGS_RST = '{af: 1'b0, ae: 1'b1, full: 1'b0, empty: 1'b1};
endpackage

// File: rtl/cfp_fifo.sv
module cfp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  // fullness judged on the pre-pop count
  assign do_push = push_i && !clr_i && (cnt != CW'(DEPTH));
  assign do_pop  = pop_i  && !clr_i && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  assign head_o = mem[rd_ptr];
  assign cnt_o  = cnt;
endmodule

// File: rtl/cfp_flags.sv
module cfp_flags
  import cfp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] ae_thr_i,
  input  logic [AW-1:0] af_thr_i,
  output fifo_flags_t   flags_o
);
  logic [CW-1:0] af_level;
  assign af_level = CW'(DEPTH) - {1'b0, af_thr_i};

  always_comb begin
    flags_o.empty = (cnt_i == '0);
    flags_o.full  = (cnt_i == CW'(DEPTH));
    flags_o.ae    = (cnt_i <= {1'b0, ae_thr_i});
    flags_o.af    = (cnt_i >= af_level);
  end
endmodule

// File: rtl/cfp_irq.sv
module cfp_irq #(
  parameter int           N       = 8,
  parameter logic [N-1:0] PREV_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= PREV_RST;
      pend_q <= '0;
    end else begin
      prev_q <= flags_i;
      // new rising edge beats a simultaneous clear
      pend_q <= (pend_q & ~clr_i) | (flags_i & ~prev_q);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/chan_fifo_pair.sv
module chan_fifo_pair
  import cfp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int BW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int NF   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [BW-1:0] bus_wdata_i,
  output logic [BW-1:0] bus_rdata_o,
  input  logic          tx_pop_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          irq_o
);
  localparam logic [AW-1:0] THR_RST = AW'(DEPTH / 16);

  logic          wr_data, rd_data, wr_ctrl;
  logic          tx_clr, rx_clr;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head, rx_head;
  logic [AW-1:0] tx_ae_q, tx_af_q, rx_ae_q, rx_af_q;
  logic [NF-1:0] ien_q, pend, pend_clr;
  fifo_flags_t   tx_flags, rx_flags;
  logic [NF-1:0] all_flags;

  assign wr_data = bus_wr_i && (bus_addr_i == ADDR_DATA);
  assign rd_data = bus_rd_i && (bus_addr_i == ADDR_DATA);
  assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign tx_clr  = wr_ctrl && bus_wdata_i[0];
  assign rx_clr  = wr_ctrl && bus_wdata_i[1];

  cfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr),
    .push_i(wr_data), .wdata_i(bus_wdata_i[DW-1:0]),
    .pop_i(tx_pop_i), .head_o(tx_head), .cnt_o(tx_cnt)
  );

  cfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr),
    .push_i(rx_push_i), .wdata_i(rx_data_i),
    .pop_i(rd_data), .head_o(rx_head), .cnt_o(rx_cnt)
  );

  cfp_flags #(.DEPTH(DEPTH)) u_tx_flags (
    .cnt_i(tx_cnt), .ae_thr_i(tx_ae_q), .af_thr_i(tx_af_q), .flags_o(tx_flags)
  );

  cfp_flags #(.DEPTH(DEPTH)) u_rx_flags (
    .cnt_i(rx_cnt), .ae_thr_i(rx_ae_q), .af_thr_i(rx_af_q), .flags_o(rx_flags)
  );

  assign all_flags = {rx_flags, tx_flags};
  assign pend_clr  = (bus_wr_i && bus_addr_i == ADDR_PEND) ? bus_wdata_i[NF-1:0] : '0;

  cfp_irq #(.N(NF), .PREV_RST({FLAGS_RST, FLAGS_RST})) u_irq (
    .clk_i, .rst_ni, .flags_i(all_flags), .clr_i(pend_clr),
    .en_i(ien_q), .pend_o(pend), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ae_q <= THR_RST;
      tx_af_q <= THR_RST;
      rx_ae_q <= THR_RST;
      rx_af_q <= THR_RST;
      ien_q   <= '0;
    end else if (bus_wr_i) begin
      case (bus_addr_i)
        ADDR_TXTHR: begin
          tx_ae_q <= bus_wdata_i[AW-1:0];
          tx_af_q <= bus_wdata_i[2*AW-1:AW];
        end
        ADDR_RXTHR: begin
          rx_ae_q <= bus_wdata_i[AW-1:0];
          rx_af_q <= bus_wdata_i[2*AW-1:AW];
        end
        ADDR_IEN: ien_q <= bus_wdata_i[NF-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_DATA:  if (rx_cnt != '0) bus_rdata_o[DW-1:0] = rx_head;
      ADDR_CTRL:  bus_rdata_o[NF-1:0] = ~all_flags;
      ADDR_TXCNT: bus_rdata_o[CW-1:0] = tx_cnt;
      ADDR_RXCNT: bus_rdata_o[CW-1:0] = rx_cnt;
      ADDR_TXTHR: bus_rdata_o[2*AW-1:0] = {tx_af_q, tx_ae_q};
      ADDR_RXTHR: bus_rdata_o[2*AW-1:0] = {rx_af_q, rx_ae_q};
      ADDR_PEND:  bus_rdata_o[NF-1:0] = pend;
      ADDR_IEN:   bus_rdata_o[NF-1:0] = ien_q;
      default: ;
    endcase
  end

  assign tx_valid_o = (tx_cnt != '0);
  assign tx_data_o  = tx_head;
endmodule

// File: rtl/cfp_chk.sv
module cfp_chk #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_clr,
  input logic          rx_clr,
  input logic          rd_data,
  input logic          rx_push_i,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    all_flags,
  input logic [7:0]    pend,
  input logic [7:0]    ien_q,
  input logic          irq_o
);
  // R3
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  // R2
  tx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_clr |=> (tx_cnt == $past(tx_cnt) || tx_cnt == $past(tx_cnt) + 1'b1 ||
                 tx_cnt + 1'b1 == $past(tx_cnt)));

  // R7
  tx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr |=> tx_cnt == '0);

  // R7
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr |=> rx_cnt == '0);

  // R4
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && rx_cnt == '0 && !rx_push_i) |=> rx_cnt == '0);

  // R8
  pend_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(all_flags[1]) |=> pend[1]);

  // R8
  pend_rx_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(all_flags[4]) |=> pend[4]);

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

bind chan_fifo_pair cfp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_clr(tx_clr), .rx_clr(rx_clr),
  .rd_data(rd_data), .rx_push_i(rx_push_i), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .all_flags(all_flags), .pend(pend), .ien_q(ien_q), .irq_o(irq_o)
);

// File: tb/chan_fifo_pair_tb.sv
module chan_fifo_pair_tb;
  localparam int D = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tx_pop = 1'b0, tx_valid;
  logic [7:0]  tx_data;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        irq;

  always #10 clk = ~clk;

  chan_fifo_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_pop_i(tx_pop), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .irq_o(irq)
  );

  // reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int         tx_ae = 16, tx_af = 16, rx_ae = 16, rx_af = 16;
  logic [7:0] m_pend = '0, m_prev = 8'h55, m_ien = '0;
  int         errors = 0, checks = 0;
  bit         done = 0;

  function automatic logic [3:0] mflags(int n, int ae, int af);
    return {n >= D - af, n <= ae, n == D, n == 0};
  endfunction

  function automatic logic [7:0] cur_flags();
    return {mflags(rxq.size(), rx_ae, rx_af), mflags(txq.size(), tx_ae, tx_af)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    bit         w = bus_wr, r = bus_rd, p = tx_pop, s = rx_push;
    logic [2:0] a = bus_addr;
    logic [15:0] wd = bus_wdata;
    logic [7:0] rd_in = rx_data;
    logic [7:0] f = cur_flags();
    bit full;
    @(posedge clk);
    m_pend = (m_pend & ~((w && a == 3'd6) ? wd[7:0] : 8'h00)) | (f & ~m_prev);
    m_prev = f;
    if (w && a == 3'd1 && wd[0]) txq.delete();
    else begin
      full = (txq.size() == D);
      if (p && txq.size() > 0) void'(txq.pop_front());
      if (w && a == 3'd0 && !full) txq.push_back(wd[7:0]);
    end
    if (w && a == 3'd1 && wd[1]) rxq.delete();
    else begin
      full = (rxq.size() == D);
      if (r && a == 3'd0 && rxq.size() > 0) void'(rxq.pop_front());
      if (s && !full) rxq.push_back(rd_in);
    end
    if (w && a == 3'd4) begin tx_ae = int'(wd[7:0]); tx_af = int'(wd[15:8]); end
    if (w && a == 3'd5) begin rx_ae = int'(wd[7:0]); rx_af = int'(wd[15:8]); end
    if (w && a == 3'd7) m_ien = wd[7:0];
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tx_pop = 0; rx_push = 0;
    // R10 / R9 every clock
    check("R10 tx_valid", tx_valid, txq.size() > 0);
    if (txq.size() > 0) check("R10 tx_data", tx_data, txq[0]);
    check("R9 irq", irq, |(m_pend & m_ien));
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic rd(string req, logic [2:0] a, logic [15:0] exp);
    bus_rd = 1; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    tick();
  endtask

  function automatic logic [15:0] data_exp();
    return (rxq.size() > 0) ? {8'h00, rxq[0]} : 16'h0000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rd("R5 reset status", 3'd1, 16'h00AA);
    rd("R2 reset txcnt", 3'd2, 16'd0);
    rd("R6 reset thr", 3'd4, 16'h1010);
    rd("R9 reset ien", 3'd7, 16'h0000);

    // R1 shared data address, tx side
    wr(3'd0, 16'h0011); wr(3'd0, 16'h0022); wr(3'd0, 16'h0033);
    rd("R2 txcnt 3", 3'd2, 16'd3);
    tx_pop = 1; tick();
    rd("R2 txcnt after pop", 3'd2, 16'd2);
    check("R1 tx head", tx_data, 8'h22);

    wr(3'd7, 16'h00FF);
    // R3 fill tx and overflow
    for (int i = 0; i < 256; i++) wr(3'd0, 16'(i + 8'h40));
    rd("R3 tx full count", 3'd2, 16'd256);
    rd("R5 tx full status", 3'd1, {8'h00, ~cur_flags()});
    rd("R8 pend after fill", 3'd6, {8'h00, m_pend});
    check("R3 head kept", tx_data, 8'h22);
    wr(3'd6, 16'h00FF);
    rd("R8 pend cleared", 3'd6, {8'h00, m_pend});

    // R7 tx clear
    wr(3'd1, 16'h0001);
    rd("R7 tx cleared", 3'd2, 16'd0);
    rd("R8 empty rise", 3'd6, {8'h00, m_pend});
    check("R8 empty pend bit", m_pend[0], 1'b1);

    // R1/R4 rx side
    rx_push = 1; rx_data = 8'hA1; tick();
    rx_push = 1; rx_data = 8'hB2; tick();
    rx_push = 1; rx_data = 8'hC3; tick();
    rd("R2 rxcnt 3", 3'd3, 16'd3);
    rd("R1 rx pop a", 3'd0, 16'h00A1);
    rd("R1 rx pop b", 3'd0, 16'h00B2);
    rd("R1 rx pop c", 3'd0, 16'h00C3);
    rd("R4 empty read", 3'd0, 16'h0000);
    rd("R4 empty count", 3'd3, 16'd0);
    rd("R4 empty read again", 3'd0, data_exp());

    // R3 rx overflow
    for (int i = 0; i < 258; i++) begin rx_push = 1; rx_data = 8'(i); tick(); end
    rd("R3 rx full count", 3'd3, 16'd256);
    rd("R1 rx head", 3'd0, 16'h0000);
    rd("R3 rx order", 3'd0, 16'h0001);
    rd("R5 rx status", 3'd1, {8'h00, ~cur_flags()});

    // R7 rx clear overriding push
    bus_wr = 1; bus_addr = 3'd1; bus_wdata = 16'h0002; rx_push = 1; rx_data = 8'h77;
    tick();
    rd("R7 rx cleared", 3'd3, 16'd0);

    // R6 thresholds
    wr(3'd4, 16'h0302);
    rd("R6 tx thr", 3'd4, 16'h0302);
    for (int i = 0; i < 4; i++) begin
      rd("R6 ae walk", 3'd1, {8'h00, ~cur_flags()});
      wr(3'd0, 16'(i));
    end
    check("R6 ae off at 3", cur_flags() & 8'h04, 8'h00);
    for (int i = 4; i < 256; i++) begin
      wr(3'd0, 16'(i));
      if (i >= 251) rd("R6 af walk", 3'd1, {8'h00, ~cur_flags()});
    end
    rd("R8 pend final", 3'd6, {8'h00, m_pend});
    wr(3'd7, 16'h0000);
    check("R9 irq masked", irq, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule